// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard-control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It works only on register numbers and control flags. Its inputs are the source fields of the instructions in decode and execute, and the destination field and write/load flags of the instructions in execute, memory and writeback. It also takes the decode-stage branch flag and the result of the branch comparator. From these it chooses the operand source for the execute-stage ALU and for the decode-stage branch comparator. It also holds fetch and decode, turns the execute slot into a bubble, and squashes the wrong-path instruction after a taken branch.

Branches resolve in decode under predict-not-taken, so a taken branch wastes one fetch slot. A result that is still in the execute stage cannot reach the decode comparator in time, and neither can a load result that has not left the memory stage. In those cases the branch waits in decode. Instruction and data memories are separate. The register file writes before it reads within a cycle, so the writeback stage never needs forwarding into decode. All outputs are combinational functions of the present inputs.

Top module: `hazard_ctrl`

## Requirements
- R1: Each execute operand select (`ex_fwd_a` for rs, `ex_fwd_b` for rt) is 2'b10 when the memory-stage instruction writes that register, 2'b01 when only the writeback-stage instruction writes it, and 2'b00 otherwise.
- R2: When both the memory-stage and writeback-stage instructions write the same register that an execute operand reads, the select is 2'b10.
- R3: Register 0 never causes forwarding on any select and never causes a stall.
- R4: A load in execute whose destination equals the decode rs or rt raises `pc_hold`, `ifid_hold` and `ex_bubble` together.
- R5: A non-load in execute that writes a register read by a non-branch in decode causes no stall.
- R6: `id_fwd_a`/`id_fwd_b` are high when a non-load instruction in the memory stage writes the decode rs/rt. A load there never raises them.
- R7: A branch in decode whose rs or rt is written by any instruction in execute stalls.
- R8: A branch in decode whose rs or rt is the destination of a load in the memory stage stalls.
- R9: An instruction in writeback never causes a stall and never raises a decode forward select.
- R10: A branch in decode with a true comparison and no stall raises `ifid_flush` and `pc_redirect`. A false comparison, or no branch, leaves both low.
- R11: When a stall is raised, `ifid_flush` and `pc_redirect` stay low even if the comparison is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| id_rs | input | RW | Decode-stage first source register |
| id_rt | input | RW | Decode-stage second source register |
| id_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_cmp_true | input | 1 | Branch comparator result (branch condition met) |
| ex_rs | input | RW | Execute-stage first source register |
| ex_rt | input | RW | Execute-stage second source register |
| ex_rd | input | RW | Execute-stage destination register |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | RW | Writeback-stage destination register |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| ex_fwd_a | output | 2 | Execute operand A source select |
| ex_fwd_b | output | 2 | Execute operand B source select |
| id_fwd_a | output | 1 | Decode comparator operand A from memory stage |
| id_fwd_b | output | 1 | Decode comparator operand B from memory stage |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode pipeline register |
| ex_bubble | output | 1 | Clear control bits of the decode/execute pipeline register |
| ifid_flush | output | 1 | Turn the fetched wrong-path instruction into a no-op |
| pc_redirect | output | 1 | Load the branch target into the program counter |

## Verification
The controller holds no state, so any wrong decision appears at the ports in the same cycle as the input pattern that triggers it. A wrong select shows up as the wrong encoding on an execute or decode select. A missed or spurious interlock shows up as the three hold/bubble outputs disagreeing with the stage fields. The interplay with branches is the part most likely to hide errors: a flush that fires while a stall is up, or a load in the memory stage that is forwarded instead of stalled. Random field values over a small register range make overlapping matches among all stages frequent.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned REG_W = 5;

  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_WBACK = 2'b01,
    SRC_MEMST = 2'b10
  } op_src_e;

  // true when a producer that writes register dst supplies register src
  function automatic logic dest_hits(input logic [REG_W-1:0] dst,
                                     input logic             wr,
                                     input logic [REG_W-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  // producer priority: memory stage before writeback stage
  function automatic op_src_e pick_src(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SRC_MEMST;
    else if (wb_hit) return SRC_WBACK;
    else             return SRC_RF;
  endfunction
endpackage

// File: rtl/hz_ex_forward.sv
module hz_ex_forward
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned NOPS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NOPS*RW-1:0] src_flat,
  input  logic [RW-1:0]      mem_rd,
  input  logic               mem_wr,
  input  logic [RW-1:0]      wb_rd,
  input  logic               wb_wr,
  output logic [NOPS*2-1:0]  sel_flat
);
  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [RW-1:0] src;
    logic          mem_hit;
    logic          wb_hit;
    op_src_e       sel;
    assign src     = src_flat[g*RW +: RW];
    assign mem_hit = dest_hits(mem_rd, mem_wr, src);
    assign wb_hit  = dest_hits(wb_rd, wb_wr, src);
    assign sel     = pick_src(mem_hit, wb_hit);
    assign sel_flat[g*2 +: 2] = sel;

    // R3
    zero_src_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> (sel == SRC_RF));
    // R2
    mem_over_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_hit && wb_hit) |-> (sel == SRC_MEMST));
    // R1
    legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != 2'b11));
  end
endmodule

// File: rtl/hz_id_forward.sv
module hz_id_forward
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  output logic          fwd_a,
  output logic          fwd_b
);
  // a load result is not ready at the memory-stage register; that case stalls
  assign fwd_a = !mem_load && dest_hits(mem_rd, mem_wr, id_rs);
  assign fwd_b = !mem_load && dest_hits(mem_rd, mem_wr, id_rt);

  // R6
  no_load_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a || fwd_b) |-> !mem_load);
  // R3
  zero_id_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> !fwd_a);
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_branch,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_load,
  output logic          load_use,
  output logic          br_wait,
  output logic          stall
);
  logic ex_hit;
  logic mem_ld_hit;

  assign ex_hit     = dest_hits(ex_rd, ex_wr, id_rs) || dest_hits(ex_rd, ex_wr, id_rt);
  assign mem_ld_hit = dest_hits(mem_rd, mem_load, id_rs) || dest_hits(mem_rd, mem_load, id_rt);

  assign load_use = ex_load && ex_hit;
  assign br_wait  = id_branch && (ex_hit || mem_ld_hit);
  assign stall    = load_use || br_wait;

  // R5
  alu_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_branch && !ex_load) |-> !stall);
  // R3
  zero_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0 && id_rt == '0) |-> !stall);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_branch,
  input  logic          id_cmp_true,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ex_bubble,
  output logic          ifid_flush,
  output logic          pc_redirect
);
  logic [3:0] sel_flat;
  logic       load_use;
  logic       br_wait;
  logic       stall;
  logic       take;

  hz_ex_forward #(.RW(RW), .NOPS(2)) u_exf (
    .clk(clk), .rst_n(rst_n),
    .src_flat({ex_rt, ex_rs}),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_rd(wb_rd), .wb_wr(wb_wr),
    .sel_flat(sel_flat)
  );
  assign ex_fwd_a = sel_flat[1:0];
  assign ex_fwd_b = sel_flat[3:2];

  hz_id_forward #(.RW(RW)) u_idf (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_load(mem_load),
    .fwd_a(id_fwd_a), .fwd_b(id_fwd_b)
  );

  hz_stall_unit #(.RW(RW)) u_stl (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_load(mem_load),
    .load_use(load_use), .br_wait(br_wait), .stall(stall)
  );

  assign take        = id_branch && id_cmp_true && !stall;
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign ex_bubble   = stall;
  assign ifid_flush  = take;
  assign pc_redirect = take;

  // R11
  flush_not_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> !pc_hold);
  // R4
  load_use_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (ex_bubble && ifid_hold && pc_hold));
  // R7
  branch_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_wait |-> !pc_redirect);
  // R10
  flush_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (id_branch && id_cmp_true));
endmodule

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
  localparam int RW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_branch, id_cmp_true, ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, pc_hold, ifid_hold, ex_bubble, ifid_flush, pc_redirect;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hazard_ctrl uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected select for one execute source
  function automatic int exp_sel(input logic [RW-1:0] s);
    if (s == 0) return 0;
    if (mem_wr && mem_rd == s) return 2;
    if (wb_wr && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic bit uses(input logic [RW-1:0] d);
    return (d != 0) && (d == id_rs || d == id_rt);
  endfunction

  function automatic bit exp_stall();
    bit ld, br;
    ld = ex_load && ex_wr && uses(ex_rd);
    br = id_branch && ((ex_wr && uses(ex_rd)) || (mem_load && uses(mem_rd)));
    return ld || br;
  endfunction

  function automatic bit exp_idf(input logic [RW-1:0] s);
    return (s != 0) && mem_wr && !mem_load && (mem_rd == s);
  endfunction

  task automatic clear_in();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_branch, id_cmp_true, ex_wr, ex_load, mem_wr, mem_load, wb_wr} = '0;
  endtask

  task automatic check_all(input string req);
    bit st;
    st = exp_stall();
    check(req, "ex_fwd_a", ex_fwd_a, exp_sel(ex_rs));
    check(req, "ex_fwd_b", ex_fwd_b, exp_sel(ex_rt));
    check(req, "id_fwd_a", id_fwd_a, exp_idf(id_rs));
    check(req, "id_fwd_b", id_fwd_b, exp_idf(id_rt));
    check(req, "pc_hold", pc_hold, st);
    check(req, "ifid_hold", ifid_hold, st);
    check(req, "ex_bubble", ex_bubble, st);
    check(req, "ifid_flush", ifid_flush, id_branch && id_cmp_true && !st);
    check(req, "pc_redirect", pc_redirect, id_branch && id_cmp_true && !st);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    clear_in();
    settle();
    check("R1", "reset ex_fwd_a", ex_fwd_a, 0);
    check("R10", "reset flush", ifid_flush, 0);
    check("R4", "reset hold", pc_hold, 0);
    rst_n = 1;

    // R1: memory-stage and writeback sources
    clear_in(); ex_rs = 3; ex_rt = 4; mem_wr = 1; mem_rd = 3; wb_wr = 1; wb_rd = 4;
    settle(); check("R1", "a mem", ex_fwd_a, 2); check("R1", "b wb", ex_fwd_b, 1);
    // R2: both match
    clear_in(); ex_rs = 6; mem_wr = 1; mem_rd = 6; wb_wr = 1; wb_rd = 6;
    settle(); check("R2", "priority", ex_fwd_a, 2);
    // R3: register zero
    clear_in(); ex_rs = 0; id_rs = 0; mem_wr = 1; mem_rd = 0; ex_wr = 1; ex_load = 1; ex_rd = 0;
    id_branch = 1; settle();
    check("R3", "zero fwd", ex_fwd_a, 0); check("R3", "zero stall", pc_hold, 0);
    check("R3", "zero idfwd", id_fwd_a, 0);
    // R4: load-use on rt
    clear_in(); id_rt = 7; ex_wr = 1; ex_load = 1; ex_rd = 7;
    settle(); check("R4", "hold", pc_hold, 1); check("R4", "ifid", ifid_hold, 1);
    check("R4", "bubble", ex_bubble, 1);
    // R5: alu dependency, non-branch
    clear_in(); id_rs = 7; ex_wr = 1; ex_rd = 7;
    settle(); check("R5", "no stall", pc_hold, 0);
    // R6: decode forward, load vs non-load
    clear_in(); id_rt = 9; mem_wr = 1; mem_rd = 9;
    settle(); check("R6", "idfwd b", id_fwd_b, 1);
    mem_load = 1; settle(); check("R6", "load no idfwd", id_fwd_b, 0);
    // R7: branch after ALU in execute
    clear_in(); id_branch = 1; id_cmp_true = 1; id_rs = 2; ex_wr = 1; ex_rd = 2;
    settle(); check("R7", "stall", pc_hold, 1); check("R11", "no flush", ifid_flush, 0);
    // R8: branch after load in memory stage
    clear_in(); id_branch = 1; id_rt = 5; mem_wr = 1; mem_load = 1; mem_rd = 5;
    settle(); check("R8", "stall", pc_hold, 1);
    // R9: writeback only
    clear_in(); id_branch = 1; id_rs = 5; wb_wr = 1; wb_rd = 5;
    settle(); check("R9", "no stall", pc_hold, 0); check("R9", "no idfwd", id_fwd_a, 0);
    // R10: taken and not taken
    clear_in(); id_branch = 1; id_cmp_true = 1;
    settle(); check("R10", "flush", ifid_flush, 1); check("R10", "redirect", pc_redirect, 1);
    id_cmp_true = 0; settle(); check("R10", "not taken", ifid_flush, 0);
    // R11: load-use plus taken branch
    clear_in(); id_branch = 1; id_cmp_true = 1; id_rs = 1; ex_wr = 1; ex_load = 1; ex_rd = 1;
    settle(); check("R11", "redirect held", pc_redirect, 0);

    // random mix, small register range to force overlaps
    for (int i = 0; i < 2000; i++) begin
      id_rs = RW'($urandom_range(0, 3)); id_rt = RW'($urandom_range(0, 3));
      ex_rs = RW'($urandom_range(0, 3)); ex_rt = RW'($urandom_range(0, 3));
      ex_rd = RW'($urandom_range(0, 3)); mem_rd = RW'($urandom_range(0, 3));
      wb_rd = RW'($urandom_range(0, 3));
      id_branch = 1'($urandom); id_cmp_true = 1'($urandom);
      ex_wr = 1'($urandom); ex_load = ex_wr & 1'($urandom);
      mem_wr = 1'($urandom); mem_load = mem_wr & 1'($urandom);
      wb_wr = 1'($urandom);
      settle();
      check_all("R1-random");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule